// File: doc/BRIEF.md
# Two-Port GPIO Register Block with Bit-Bang Side-Band

This block holds the general-purpose I/O registers for two ports, called A and D, behind a simple word-addressed bus. Each port has three registers: an output value, an input view and an output enable. The other words of a 23-word (0x5C-byte) window are plain scratch storage. A write takes effect at the rising clock edge. A read is combinational from the current address. The two low address bits select a byte inside a word and have no effect.

Two peripherals hang off the ports through side-band wires. Three bits of the port A output register drive the control strobes of a NAND flash: chip enable, command latch and address latch. The input view of port A reports the flash ready line. Port D drives a serial temperature sensor by bit-banging. When a write to the port D output register flips its clock bit, the block emits a one-cycle edge strobe, together with the new clock level and the serial data bit, in the same cycle as the write. The input view of port D reports the sensor's serial output.

Top module: `gpio_bitbang_regs`

## Requirements
- R1: After reset every stored word reads as zero. The NAND strobes `nandAle`, `nandCle` and `nandCe` are low, and the stored port D clock bit is low.
- R2: A write to word index 0 (port A output) stores the value. From the next cycle `nandAle` equals bit 6, `nandCle` equals bit 5 and `nandCe` equals bit 4 of that value.
- R3: A read of word index 1 returns (word 0 AND word 2), with bit 7 forced to 1 while `nandReady` is high.
- R4: A read of word index 17 (0x11) returns (word 16 AND word 18), with bit 4 forced to 1 while `sensIn` is high.
- R5: In the same cycle as a write to word index 16 (0x10) whose bit 1 differs from the stored bit 1, `sensEdge` is high for that one cycle. At the same time `sensLevel` equals bit 1 and `sensData` equals bit 4 of the written value. A write to index 16 that leaves bit 1 unchanged, or a write to any other index, gives no strobe.
- R6: Every in-window index other than 1 and 17 returns the last value written to it. Writes to indices 1 and 17 change nothing that can be read.
- R7: The word index is byte address bits [6:2], and address bits [1:0] are ignored. Indices 23 and above are outside the window: writes to them change nothing, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request for the current address |
| addr | input | 7 | Byte address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for addr |
| nandReady | input | 1 | Flash ready line |
| nandAle | output | 1 | Flash address-latch strobe |
| nandCle | output | 1 | Flash command-latch strobe |
| nandCe | output | 1 | Flash chip enable |
| sensIn | input | 1 | Serial data from the sensor |
| sensEdge | output | 1 | One-cycle clock-edge strobe toward the sensor |
| sensLevel | output | 1 | Clock level of the edge (valid with sensEdge) |
| sensData | output | 1 | Serial data toward the sensor (valid with sensEdge) |

## Verification
Every index from 0 to 31 is written with a pattern that depends on its index. Each index is then read back under all four combinations of `nandReady` and `sensIn`. This separates the plain words, the two merged input views and the out-of-window words, and it shows whether each side-band bit lands only on its own bit. A second pass repeats the writes with different low address bits to show that the byte offset is ignored. A sequence of port D writes that alternately flips and keeps the clock bit, with the data bit varying, separates a true edge from a rewrite of the same level. Port A writes then walk the three strobe bits separately.

// File: rtl/gpio_bb_pkg.sv
package gpio_bb_pkg;
  localparam int WORD_COUNT = 23;
  localparam int IDX_W      = 5;

  localparam int IDX_PA_OUT = 0;
  localparam int IDX_PA_IN  = 1;
  localparam int IDX_PA_OE  = 2;
  localparam int IDX_PD_OUT = 16;
  localparam int IDX_PD_IN  = 17;
  localparam int IDX_PD_OE  = 18;

  localparam int BIT_ALE   = 6;
  localparam int BIT_CLE   = 5;
  localparam int BIT_CE    = 4;
  localparam int BIT_READY = 7;
  localparam int BIT_SCLK  = 1;
  localparam int BIT_SDATA = 4;
  localparam int BIT_SIN   = 4;

  typedef struct packed {
    logic             wrStore;
    logic             wrPaOut;
    logic             sensEdge;
    logic [IDX_W-1:0] wrIdx;
    logic             rdInWin;
    logic             rdPaIn;
    logic             rdPdIn;
    logic [IDX_W-1:0] rdIdx;
  } ctrl_t;
endpackage

// File: rtl/gpio_bb_ctrl.sv
module gpio_bb_ctrl
  import gpio_bb_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrSclk,
  input  logic              curSclk,
  output ctrl_t             ctrl
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] wordIdx;
  logic              inWin;
  logic [IDX_W-1:0]  idx;

  assign wordIdx = addr[ADDR_W-1:2];
  assign inWin   = wordIdx < WIDX_W'(WORD_COUNT);
  assign idx     = wordIdx[IDX_W-1:0];

  always_comb begin
    ctrl          = '0;
    ctrl.wrIdx    = idx;
    ctrl.rdIdx    = idx;
    ctrl.rdInWin  = inWin;
    ctrl.rdPaIn   = inWin && (idx == IDX_W'(IDX_PA_IN));
    ctrl.rdPdIn   = inWin && (idx == IDX_W'(IDX_PD_IN));
    ctrl.wrStore  = wrEn && inWin && (idx != IDX_W'(IDX_PA_IN))
                    && (idx != IDX_W'(IDX_PD_IN));
    ctrl.wrPaOut  = wrEn && inWin && (idx == IDX_W'(IDX_PA_OUT));
    ctrl.sensEdge = wrEn && inWin && (idx == IDX_W'(IDX_PD_OUT))
                    && (wrSclk != curSclk);
  end
endmodule

// File: rtl/gpio_bb_datapath.sv
module gpio_bb_datapath
  import gpio_bb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] wrData,
  input  logic              nandReady,
  input  logic              sensIn,
  output logic [DATA_W-1:0] rdData,
  output logic              nandAle,
  output logic              nandCle,
  output logic              nandCe,
  output logic              curSclk
);
  logic [DATA_W-1:0] regFile [WORD_COUNT];

  for (genvar g = 0; g < WORD_COUNT; g++) begin : gWord
    if (g == IDX_PA_IN || g == IDX_PD_IN) begin : gView
      assign regFile[g] = '0;
    end else begin : gStore
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regFile[g] <= '0;
        else if (ctrl.wrStore && ctrl.wrIdx == IDX_W'(g)) regFile[g] <= wrData;
      end
    end
  end

  logic [DATA_W-1:0] paView, pdView;

  always_comb begin
    paView = regFile[IDX_PA_OUT] & regFile[IDX_PA_OE];
    paView[BIT_READY] = paView[BIT_READY] | nandReady;
    pdView = regFile[IDX_PD_OUT] & regFile[IDX_PD_OE];
    pdView[BIT_SIN] = pdView[BIT_SIN] | sensIn;
  end

  always_comb begin
    if (!ctrl.rdInWin)    rdData = '0;
    else if (ctrl.rdPaIn) rdData = paView;
    else if (ctrl.rdPdIn) rdData = pdView;
    else                  rdData = regFile[ctrl.rdIdx];
  end

  assign nandAle = regFile[IDX_PA_OUT][BIT_ALE];
  assign nandCle = regFile[IDX_PA_OUT][BIT_CLE];
  assign nandCe  = regFile[IDX_PA_OUT][BIT_CE];
  assign curSclk = regFile[IDX_PD_OUT][BIT_SCLK];

  // R5: a strobe is always followed by a flipped stored clock bit
  p_edge_flips_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.sensEdge |=> curSclk != $past(curSclk));
  // R5: without a strobe the stored clock bit never moves
  p_no_edge_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.sensEdge |=> $stable(curSclk));
  // R2: flash strobes follow the written bits one cycle later
  p_strobes_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrPaOut |=> nandAle == $past(wrData[BIT_ALE])
                   && nandCle == $past(wrData[BIT_CLE])
                   && nandCe == $past(wrData[BIT_CE]));
  // R3: ready high always shows on the port A view
  p_ready_merge_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.rdPaIn && nandReady |-> rdData[BIT_READY]);
  // R7: out-of-window reads are zero
  p_oob_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.rdInWin |-> rdData == '0);
endmodule

// File: rtl/gpio_bitbang_regs.sv
module gpio_bitbang_regs
  import gpio_bb_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              nandReady,
  output logic              nandAle,
  output logic              nandCle,
  output logic              nandCe,
  input  logic              sensIn,
  output logic              sensEdge,
  output logic              sensLevel,
  output logic              sensData
);
  ctrl_t ctrl;
  logic  curSclk;

  gpio_bb_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrEn    (wrEn),
    .addr    (addr),
    .wrSclk  (wrData[BIT_SCLK]),
    .curSclk (curSclk),
    .ctrl    (ctrl)
  );

  gpio_bb_datapath #(.DATA_W(DATA_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .wrData    (wrData),
    .nandReady (nandReady),
    .sensIn    (sensIn),
    .rdData    (rdData),
    .nandAle   (nandAle),
    .nandCle   (nandCle),
    .nandCe    (nandCe),
    .curSclk   (curSclk)
  );

  assign sensEdge  = ctrl.sensEdge;
  assign sensLevel = wrData[BIT_SCLK];
  assign sensData  = wrData[BIT_SDATA];

  // R5: a strobe only accompanies a write
  p_edge_needs_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    sensEdge |-> wrEn);
endmodule

// File: tb/sim_gpio_bitbang_regs.sv
module sim_gpio_bitbang_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0;
  logic [6:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        nandReady = 0, sensIn = 0;
  logic        nandAle, nandCle, nandCe, sensEdge, sensLevel, sensData;

  int checks = 0, fails = 0;
  logic [31:0] model [32];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bitbang_regs u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .nandReady(nandReady), .nandAle(nandAle),
    .nandCle(nandCle), .nandCe(nandCe), .sensIn(sensIn),
    .sensEdge(sensEdge), .sensLevel(sensLevel), .sensData(sensData));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(int idx);
    logic [31:0] v;
    if (idx >= 23) return 32'h0;
    if (idx == 1) begin
      v = model[0] & model[2];
      v[7] = v[7] | nandReady;
      return v;
    end
    if (idx == 17) begin
      v = model[16] & model[18];
      v[4] = v[4] | sensIn;
      return v;
    end
    return model[idx];
  endfunction

  task automatic doWrite(int idx, logic [1:0] off, logic [31:0] d);
    logic expEdge;
    expEdge = (idx == 16) && (d[1] != model[16][1]);
    @(negedge clk);
    wrEn = 1; addr = {idx[4:0], off}; wrData = d;
    #1;
    check("R5 edge strobe", {31'h0, sensEdge}, {31'h0, expEdge});
    if (expEdge) begin
      check("R5 edge level", {31'h0, sensLevel}, {31'h0, d[1]});
      check("R5 edge data", {31'h0, sensData}, {31'h0, d[4]});
    end
    @(negedge clk);
    wrEn = 0;
    if (idx < 23 && idx != 1 && idx != 17) model[idx] = d;
  endtask

  task automatic doRead(int idx, logic [1:0] off, string req);
    addr = {idx[4:0], off};
    #1;
    check(req, rdData, expRead(idx));
  endtask

  task automatic checkPins();
    #1;
    check("R2 nand strobes", {29'h0, nandAle, nandCle, nandCe},
          {29'h0, model[0][6], model[0][5], model[0][4]});
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 32; i++) doRead(i, 2'b00, "R1 reset read");
    check("R1 reset strobes", {29'h0, nandAle, nandCle, nandCe}, 32'h0);
    // R6 R7 sweep of writes
    for (int i = 0; i < 32; i++)
      doWrite(i, 2'(i), 32'hA5C3_0F96 ^ (i * 32'h0101_0113));
    for (int c = 0; c < 4; c++) begin
      nandReady = c[0]; sensIn = c[1];
      for (int i = 0; i < 32; i++) begin
        string rq;
        rq = (i == 1) ? "R3 port A view" : (i == 17) ? "R4 port D view" :
             (i >= 23) ? "R7 out of window" : "R6 plain word";
        doRead(i, 2'(c), rq);
      end
    end
    // R7 byte offset ignored on writes
    for (int i = 0; i < 24; i++) doWrite(i, 2'(3 - (i % 4)), ~(i * 32'h0700_0009));
    for (int i = 0; i < 32; i++) doRead(i, 2'(i), "R7 offset ignored");
    // R3 R4 masks with full enables and zero outputs
    doWrite(2, 0, 32'hFFFF_FFFF); doWrite(0, 0, 32'h0000_0000);
    doWrite(18, 0, 32'hFFFF_FFFF); doWrite(16, 0, 32'h0000_0000);
    for (int c = 0; c < 4; c++) begin
      nandReady = c[0]; sensIn = c[1];
      doRead(1, 0, "R3 ready only"); doRead(17, 0, "R4 sensor only");
    end
    // R5 clock toggling sequence
    for (int k = 0; k < 16; k++) begin
      logic [31:0] d;
      d = 32'h0;
      d[1] = k[1] ^ k[0];
      d[4] = k[2];
      d[8] = k[3];
      doWrite(16, 0, d);
      doRead(16, 0, "R5 stored clock");
    end
    doWrite(15, 0, 32'h0000_0002);
    // R2 walk strobes
    for (int k = 0; k < 8; k++) begin
      doWrite(0, 0, {25'h0, k[2:0], 4'h0});
      checkPins();
    end
    done = 1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (done);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule